// File: doc/BRIEF.md
# Printer Port Register Block

This block is the host-side register set of a classic byte-wide printer port. A simple register bus reads and writes four pieces of state: a latch for outgoing data, a latch for incoming data, a status byte and a control byte. The busy and acknowledge bits of the status byte are not inputs. They move through a small handshake that status reads and control writes drive, so a driver that polls status after each strobe sees the sequence it expects from a printer.

When software raises the strobe bit while the port is selected and out of initialise, the block places the outgoing data byte on a byte stream with a one-cycle valid pulse. An interrupt-pending flag is set when the strobe falls while interrupts are enabled. A status read clears it, and the interrupt output follows the flag as a level. Incoming data is sampled from an input bus while the direction bit selects input.

Top module: `prn_port_regs`

## Requirements
- R1: Only the low three address bits are decoded: offset 0 is data, offset 1 is status and offset 2 is control. A read of offsets 3 to 7 returns 0xFF. A write to offsets 1 and 3 to 7 changes no state.
- R2: A control write stores the written byte with bits 7 and 6 forced to 1.
- R3: A control write whose bit 2 (initialise) is 0 sets status to 0xD8: bit 7 busy-complement, bit 6 ack, bit 4 online and bit 3 error-complement set, all other bits clear.
- R4: A control write with bits 2 (initialise) and 3 (select) at 1 and bit 0 (strobe) at 1 clears status bit 7. If the stored strobe bit was 0 before the write, the outgoing data latch is sent as one byte on the output stream.
- R5: A control write with bits 2 and 3 at 1 and bit 0 at 0 sets interrupt-pending when the control value stored before the write has bit 4 (interrupt enable) at 1.
- R6: A status read returns the status held before the read and clears interrupt-pending. If status bit 7 and stored strobe bit 0 are both 0, the read then clears bit 6 when bit 6 is 1, or sets bits 6 and 7 when bit 6 is 0. Otherwise the status is unchanged.
- R7: A data read returns the incoming latch when control bit 5 (direction) is 1 and the outgoing latch when it is 0. The incoming latch loads the input bus on every clock while the stored direction bit is 1.
- R8: Reset sets both data latches to 0xFF, status to 0xD9 and control to 0xCC, and clears interrupt-pending and the output valid.
- R9: The interrupt output is high exactly while interrupt-pending is set.
- R10: Read data appears on the read-data port in the cycle after read-enable and holds until the next read. A read and a write to the same offset in one cycle return the value from before the write.
- R11: The output valid is a single-cycle pulse, visible in the cycle after the strobe write, carrying the outgoing latch value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address (low three bits decoded) |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_data_in | input | 8 | Incoming data bus, sampled while direction is input |
| out_byte | output | 8 | Emitted data byte |
| out_valid | output | 1 | One-cycle valid for out_byte |
| irq | output | 1 | Level interrupt |

## Verification
A read and a write can reach the same offset in one cycle. On the control register, the read must show the old control byte while the new one is stored. On the data register, the read must show the old outgoing latch while the new byte is latched. The bench also samples the input bus every cycle while a data read is in flight, so a latch update and a read fall on the same edge. Directed cases and random cycles with both enables raised together provoke these collisions. A bench model computes the pre-edge value for each read and the post-edge state for later reads, and the bench checks the outputs against that model.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

  // control bit positions
  localparam int CB_STROBE = 0;
  localparam int CB_INIT   = 2;
  localparam int CB_SELECT = 3;
  localparam int CB_IRQEN  = 4;
  localparam int CB_DIR    = 5;

  // status bit positions
  localparam int SB_BUSYN  = 7;
  localparam int SB_ACK    = 6;

  localparam logic [BYTE_W-1:0] CTRL_FORCE  = 8'hC0;
  localparam logic [BYTE_W-1:0] STAT_INITV  = 8'hD8;
  localparam logic [BYTE_W-1:0] STAT_RST    = 8'hD9;
  localparam logic [BYTE_W-1:0] CTRL_RST    = 8'hCC;
  localparam logic [BYTE_W-1:0] DATA_RST    = 8'hFF;
  localparam logic [BYTE_W-1:0] OPEN_READ   = 8'hFF;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/prn_addr_dec.sv
module prn_addr_dec
  import prn_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output reg_sel_e          sel,
  output logic              wr_data,
  output logic              wr_ctrl,
  output logic              rd_stat,
  output logic              rd_any
);
  logic [OFS_W-1:0] ofs;

  generate
    if (ADDR_W > OFS_W) begin : g_wide
      logic [ADDR_W-OFS_W-1:0] unused_hi;
      assign ofs       = addr[OFS_W-1:0];
      assign unused_hi = addr[ADDR_W-1:OFS_W];
    end else begin : g_narrow
      assign ofs = OFS_W'(addr);
    end
  endgenerate

  always_comb begin
    unique case (ofs)
      OFS_DATA: sel = SEL_DATA;
      OFS_STAT: sel = SEL_STAT;
      OFS_CTRL: sel = SEL_CTRL;
      default:  sel = SEL_NONE;
    endcase
  end

  assign wr_data = wr && (sel == SEL_DATA);
  assign wr_ctrl = wr && (sel == SEL_CTRL);
  assign rd_stat = rd && (sel == SEL_STAT);
  assign rd_any  = rd;
endmodule

// File: rtl/prn_hs_ctrl.sv
module prn_hs_ctrl
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              rd_stat,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic              pend_q,
  output logic              emit
);
  logic [BYTE_W-1:0] ctrl_d, stat_d, ctrl_new;
  logic              pend_d;
  logic              ctrl_en, stat_en, pend_en;

  assign ctrl_new = wdata | CTRL_FORCE;

  always_comb begin
    ctrl_d = ctrl_q;
    stat_d = stat_q;
    pend_d = pend_q;
    emit   = 1'b0;
    if (wr_ctrl) begin
      ctrl_d = ctrl_new;
      if (!ctrl_new[CB_INIT]) begin
        stat_d = STAT_INITV;
      end else if (ctrl_new[CB_SELECT]) begin
        if (ctrl_new[CB_STROBE]) begin
          stat_d[SB_BUSYN] = 1'b0;
          emit             = !ctrl_q[CB_STROBE];
        end else if (ctrl_q[CB_IRQEN]) begin
          pend_d = 1'b1;
        end
      end
    end
    if (rd_stat) begin
      pend_d = 1'b0;
      if (!stat_q[SB_BUSYN] && !ctrl_q[CB_STROBE]) begin
        if (stat_q[SB_ACK]) begin
          stat_d[SB_ACK] = 1'b0;
        end else begin
          stat_d[SB_ACK]   = 1'b1;
          stat_d[SB_BUSYN] = 1'b1;
        end
      end
    end
  end

  assign ctrl_en = wr_ctrl;
  assign stat_en = wr_ctrl | rd_stat;
  assign pend_en = wr_ctrl | rd_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      stat_q <= STAT_RST;
      pend_q <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (stat_en) stat_q <= stat_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  AST_CTRL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q == ($past(wdata) | 8'hC0))); // R2
  AST_INIT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[2]) |=> (stat_q == 8'hD8)); // R3
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[2] && wdata[3] && wdata[0]) |=> !stat_q[7]); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> !pend_q); // R6
endmodule

// File: rtl/prn_data_path.sv
module prn_data_path
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              dir_in,
  input  logic [BYTE_W-1:0] pin_in,
  input  logic              emit,
  output logic [BYTE_W-1:0] dout_q,
  output logic [BYTE_W-1:0] din_q,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid
);
  logic [BYTE_W-1:0] dout_d, din_d, ob_d;
  logic              ov_d;

  always_comb begin
    dout_d = wr_data ? wdata  : dout_q;
    din_d  = dir_in  ? pin_in : din_q;
    ob_d   = emit    ? dout_q : out_byte;
    ov_d   = emit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q    <= DATA_RST;
      din_q     <= DATA_RST;
      out_byte  <= DATA_RST;
      out_valid <= 1'b0;
    end else begin
      if (wr_data) dout_q   <= dout_d;
      if (dir_in)  din_q    <= din_d;
      if (emit)    out_byte <= ob_d;
      out_valid <= ov_d;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R11
  AST_BYTE_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> (out_byte == $past(dout_q))); // R4
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import prn_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        pin_data_in,
  output logic [7:0]        out_byte,
  output logic              out_valid,
  output logic              irq
);
  reg_sel_e          sel;
  logic              wr_data, wr_ctrl, rd_stat, rd_any, emit, pend_q;
  logic [BYTE_W-1:0] ctrl_q, stat_q, dout_q, din_q;
  logic [BYTE_W-1:0] rmux, rdata_d;

  prn_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .sel(sel),
    .wr_data(wr_data), .wr_ctrl(wr_ctrl), .rd_stat(rd_stat), .rd_any(rd_any)
  );

  prn_hs_ctrl u_hs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .rd_stat(rd_stat),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .stat_q(stat_q), .pend_q(pend_q),
    .emit(emit)
  );

  prn_data_path u_dp (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wdata(bus_wdata),
    .dir_in(ctrl_q[CB_DIR]), .pin_in(pin_data_in), .emit(emit),
    .dout_q(dout_q), .din_q(din_q), .out_byte(out_byte), .out_valid(out_valid)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: rmux = ctrl_q[CB_DIR] ? din_q : dout_q;
      SEL_STAT: rmux = stat_q;
      SEL_CTRL: rmux = ctrl_q;
      default:  rmux = OPEN_READ;
    endcase
    rdata_d = rd_any ? rmux : bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= OPEN_READ;
    end else if (rd_any) begin
      bus_rdata <= rdata_d;
    end
  end

  assign irq = pend_q;

  AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr[2:0] > 3'd2)) |=> (bus_rdata == 8'hFF)); // R1
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R10
  AST_STAT_READ_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[2:0] == 3'd1) |=> !irq); // R9
endmodule

// File: tb/prn_port_regs_tb_top.sv
module prn_port_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk, rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata, pin_data_in, out_byte;
  logic       out_valid, irq;

  int checks, errors, cycles;
  logic       finished;

  // model state
  logic [7:0] m_dw, m_dr, m_st, m_ct, m_rd, m_ob;
  logic       m_pd, m_ov;

  prn_port_regs #(.ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_data_in(pin_data_in), .out_byte(out_byte), .out_valid(out_valid),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      report();
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_value(input logic [2:0] o);
    case (o)
      3'd0: return m_ct[5] ? m_dr : m_dw;   // R7
      3'd1: return m_st;
      3'd2: return m_ct;
      default: return 8'hFF;                // R1
    endcase
  endfunction

  // one bus cycle: drive at negedge, model the edge, check after it
  task automatic op(input logic rd, input logic wr, input logic [7:0] a,
                    input logic [7:0] wd, input logic [7:0] pin);
    logic [7:0] o_dw, o_st, o_ct, nv;
    logic [2:0] o;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; pin_data_in = pin;
    o = a[2:0];
    o_dw = m_dw; o_st = m_st; o_ct = m_ct;
    if (rd) m_rd = rd_value(o);
    m_ov = 1'b0;
    if (o_ct[5]) m_dr = pin;
    if (wr && o == 3'd0) m_dw = wd;
    if (wr && o == 3'd2) begin
      nv = wd | 8'hC0;
      m_ct = nv;
      if (!nv[2]) m_st = 8'hD8;
      else if (nv[3]) begin
        if (nv[0]) begin
          m_st[7] = 1'b0;
          if (!o_ct[0]) begin m_ov = 1'b1; m_ob = o_dw; end
        end else if (o_ct[4]) m_pd = 1'b1;
      end
    end
    if (rd && o == 3'd1) begin
      m_pd = 1'b0;
      if (!o_st[7] && !o_ct[0]) begin
        if (o_st[6]) m_st[6] = 1'b0;
        else begin m_st[6] = 1'b1; m_st[7] = 1'b1; end
      end
    end
    @(posedge clk);
    #1;
    if (rd) chk("R10 rdata", bus_rdata, m_rd);
    chk("R9 irq", {7'd0, irq}, {7'd0, m_pd});
    chk("R11 out_valid", {7'd0, out_valid}, {7'd0, m_ov});
    if (m_ov) chk("R4 out_byte", out_byte, m_ob);
  endtask

  task automatic rd_reg(input logic [7:0] a, input string req, input logic [7:0] exp);
    op(1'b1, 1'b0, a, 8'h00, 8'h00);
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    checks = 0; errors = 0; cycles = 0; finished = 1'b0;
    bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pin_data_in = 0;
    m_dw = 8'hFF; m_dr = 8'hFF; m_st = 8'hD9; m_ct = 8'hCC;
    m_pd = 0; m_ov = 0; m_rd = 8'hFF; m_ob = 8'hFF;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 irq at reset", {7'd0, irq}, 8'd0);
    chk("R8 valid at reset", {7'd0, out_valid}, 8'd0);
    @(negedge clk); rst_n = 1;

    // R8 reset values
    rd_reg(8'h02, "R8 control reset", 8'hCC);
    rd_reg(8'h01, "R8 status reset", 8'hD9);
    rd_reg(8'h00, "R8 data reset", 8'hFF);

    // R1 unmapped offsets and aliasing
    op(1'b0, 1'b1, 8'h05, 8'h12, 8'h00);
    rd_reg(8'h05, "R1 unmapped read", 8'hFF);
    op(1'b0, 1'b1, 8'h01, 8'h00, 8'h00);
    rd_reg(8'h01, "R1 status write ignored", 8'hD9);
    op(1'b0, 1'b1, 8'h08, 8'h5A, 8'h00);
    rd_reg(8'h10, "R1 alias data", 8'h5A);

    // R2 forced bits, R3 initialise
    op(1'b0, 1'b1, 8'h0A, 8'h08, 8'h00);
    rd_reg(8'h02, "R2 control forced", 8'hC8);
    rd_reg(8'h01, "R3 init status", 8'hD8);

    // R4 strobe handshake and emission
    op(1'b0, 1'b1, 8'h02, 8'h0C, 8'h00);
    op(1'b0, 1'b1, 8'h02, 8'h0D, 8'h00);
    chk("R4 emit", {7'd0, out_valid}, 8'd1);
    chk("R4 byte", out_byte, 8'h5A);
    op(1'b0, 1'b1, 8'h02, 8'h0D, 8'h00);
    chk("R4 no repeat emit", {7'd0, out_valid}, 8'd0);
    op(1'b0, 1'b1, 8'h02, 8'h0C, 8'h00);
    rd_reg(8'h01, "R6 status busy low", 8'h58);
    rd_reg(8'h01, "R6 ack cleared", 8'h18);
    rd_reg(8'h01, "R6 ack and busy set", 8'hD8);

    // R5 interrupt pending
    op(1'b0, 1'b1, 8'h02, 8'h1C, 8'h00);
    op(1'b0, 1'b1, 8'h02, 8'h0C, 8'h00);
    chk("R5 irq set", {7'd0, irq}, 8'd1);
    rd_reg(8'h01, "R6 read with irq", m_rd);
    chk("R6 irq cleared", {7'd0, irq}, 8'd0);

    // R7 direction and R10 same-cycle read and write
    op(1'b0, 1'b1, 8'h02, 8'h2C, 8'h3C);
    op(1'b0, 1'b0, 8'h00, 8'h00, 8'hA5);
    rd_reg(8'h00, "R7 incoming latch", 8'hA5);
    op(1'b1, 1'b1, 8'h02, 8'h0C, 8'h77);
    chk("R10 old control on collision", bus_rdata, 8'hEC);
    op(1'b1, 1'b1, 8'h00, 8'h99, 8'h00);
    chk("R10 old data on collision", bus_rdata, 8'h5A);
    rd_reg(8'h00, "R7 outgoing latch", 8'h99);

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a, w;
      logic r, wr;
      a  = 8'($urandom);
      if ($urandom_range(0, 3) != 0) a[2:0] = 3'($urandom_range(0, 2));
      w  = 8'($urandom);
      if ($urandom_range(0, 1) != 0) w[3:2] = 2'b11;
      r  = 1'($urandom);
      wr = 1'($urandom);
      op(r, wr, a, w, 8'($urandom));
    end

    finished = 1'b1;
    report();
  end
endmodule